// File: doc/BRIEF.md
# Bridge Parity Error Reporting Unit

This unit watches the sampled bus values on both sides of a two-sided PCI bridge and recomputes even parity over each address phase, and over each data phase of a Type 0 configuration write aimed at the bridge's own space. The recomputed parity is compared with PAR one clock after the phase it covers. The unit then decides three things. It decides whether the secondary side may claim the transaction. It decides whether to drive PERR# or primary SERR#. It also sets the sticky error flags that the status registers hold.

Secondary-side address errors are governed by the parity-response enable in the bridge control register. Primary-side errors are governed by the parity-response enable in the command register. A configuration write carrying bad data is still committed to the register file. The unit only reports the error for such a write. All outputs are registered and appear two clocks after the phase they describe.

Top module: `bpr_unit`

## Requirements
- R1: Parity is even over the address/data lines and the four byte-enable lines, and PAR is compared in the clock after the phase. Every decision for a phase appears on the outputs exactly two clocks after that phase. A single flipped AD bit or a flipped PAR bit counts as an error.
- R2: On a secondary address phase, `sec_claim` pulses for one clock when `sec_hit` was set, unless the phase had a parity error while `bctl_perr_en` was set. In that case the claim is withheld. With `bctl_perr_en` clear, an erroneous phase is claimed normally.
- R3: Any secondary address parity error sets `err_sts[2]` (secondary detected parity error), whatever the enables are.
- R4: A secondary address parity error pulses `serr_n` low and sets `err_sts[1]` (signaled system error) only when both `cmd_serr_en` and `bctl_perr_en` are set.
- R5: A primary address parity error sets `err_sts[0]` (primary detected parity error). It pulses `serr_n` and sets `err_sts[1]` only when both `cmd_serr_en` and `cmd_perr_en` are set.
- R6: Every data phase of a Type 0 configuration write pulses `cfg_commit`, bad parity or not. On a parity error, `perr_n` goes low for one clock only if `cmd_perr_en` is set.
- R7: A configuration-write data parity error sets `err_sts[0]` regardless of `cmd_perr_en`.
- R8: The status flags are sticky. Setting bit i of `sts_clr` for one clock clears only flag i. A flag that is set and cleared in the same clock stays set.
- R9: `perr_n` and `serr_n` are one-clock low pulses. Primary and secondary address errors in the same clock produce a single SERR# pulse.
- R10: Primary data phases that are not Type 0 configuration writes are not checked. A bad PAR on such a phase leaves `perr_n`, `serr_n`, `cfg_commit` and the flags untouched.
- R11: During and after reset, `perr_n` and `serr_n` are high and `err_sts`, `sec_claim` and `cfg_commit` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_ad | input | 32 | Primary sampled address/data |
| pri_cbe | input | 4 | Primary sampled command/byte enables |
| pri_par | input | 1 | Primary PAR, valid the clock after a phase |
| pri_addr_ph | input | 1 | Primary address phase strobe |
| pri_data_ph | input | 1 | Primary data phase strobe |
| pri_cfg0_wr | input | 1 | Data phase belongs to a Type 0 configuration write to own space |
| sec_ad | input | 32 | Secondary sampled address/data |
| sec_cbe | input | 4 | Secondary sampled command/byte enables |
| sec_par | input | 1 | Secondary PAR, valid the clock after a phase |
| sec_addr_ph | input | 1 | Secondary address phase strobe |
| sec_hit | input | 1 | Secondary address decodes to or across the bridge |
| cmd_perr_en | input | 1 | Command register parity-response enable |
| cmd_serr_en | input | 1 | Command register SERR# enable |
| bctl_perr_en | input | 1 | Bridge control parity-response enable |
| sts_clr | input | 3 | Write-1-to-clear strobes for the status flags |
| err_sts | output | 3 | Sticky flags: [0] primary detected, [1] signaled system error, [2] secondary detected |
| sec_claim | output | 1 | One-clock permission to claim on the secondary side |
| perr_n | output | 1 | Active-low parity error pulse |
| serr_n | output | 1 | Active-low system error pulse |
| cfg_commit | output | 1 | One-clock pulse to commit a configuration write |

## Verification
The bound checker checks the following on every clock. PERR# and SERR# are single-clock pulses. Each pulse agrees with the enable it depends on and with the status flag it implies. A secondary error under bridge-control response never coexists with a claim. Set flags persist until their own clear bit is written. Whether a specific single-bit flip is detected, and the outcomes under all four enable combinations, can only be shown by the bench's directed phases. The same holds for the clear-versus-set collision, the single SERR# pulse for coincident errors, and unchecked ordinary data phases.

// File: rtl/bpr_pkg.sv
package bpr_pkg;
  localparam int STS_PDPE = 0;
  localparam int STS_PSSE = 1;
  localparam int STS_SDPE = 2;
  localparam int NSTS     = 3;

  // Result of one bus parity check, valid the clock after a phase
  typedef struct packed {
    logic addr_seen;
    logic data_seen;
    logic tag;
    logic addr_err;
    logic data_err;
  } par_chk_t;
endpackage

// File: rtl/bpr_par_chk.sv
module bpr_par_chk
  import bpr_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] ad,
  input  logic [BE_W-1:0] cbe,
  input  logic            par,
  input  logic            addr_ph,
  input  logic            data_ph,
  input  logic            tag,
  output par_chk_t        res
);
  logic exp_q, addr_q, data_q, tag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_q  <= 1'b0;
      addr_q <= 1'b0;
      data_q <= 1'b0;
      tag_q  <= 1'b0;
    end else begin
      exp_q  <= ^{ad, cbe};
      addr_q <= addr_ph;
      data_q <= data_ph;
      tag_q  <= tag;
    end
  end

  logic mismatch;
  assign mismatch = exp_q ^ par;

  always_comb begin
    res.addr_seen = addr_q;
    res.data_seen = data_q;
    res.tag       = tag_q;
    res.addr_err  = addr_q & mismatch;
    res.data_err  = data_q & mismatch;
  end
endmodule

// File: rtl/bpr_err_policy.sv
module bpr_err_policy
  import bpr_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  par_chk_t        pri,
  input  par_chk_t        sec,
  input  logic            cmd_perr_en,
  input  logic            cmd_serr_en,
  input  logic            bctl_perr_en,
  output logic [NSTS-1:0] sts_set,
  output logic            sec_claim,
  output logic            perr_n,
  output logic            serr_n,
  output logic            cfg_commit
);
  logic pri_cfg_err, serr_req, perr_req, claim_d, commit_d;
  logic unused_sec_data;
  assign unused_sec_data = sec.data_seen ^ sec.data_err;

  always_comb begin
    pri_cfg_err = pri.data_err & pri.tag;
    serr_req    = cmd_serr_en & ((pri.addr_err & cmd_perr_en) |
                                 (sec.addr_err & bctl_perr_en));
    perr_req    = pri_cfg_err & cmd_perr_en;
    claim_d     = sec.addr_seen & sec.tag & ~(sec.addr_err & bctl_perr_en);
    commit_d    = pri.data_seen & pri.tag;
    sts_set           = '0;
    sts_set[STS_PDPE] = pri.addr_err | pri_cfg_err;
    sts_set[STS_PSSE] = serr_req;
    sts_set[STS_SDPE] = sec.addr_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_claim  <= 1'b0;
      perr_n     <= 1'b1;
      serr_n     <= 1'b1;
      cfg_commit <= 1'b0;
    end else begin
      sec_claim  <= claim_d;
      perr_n     <= ~perr_req;
      serr_n     <= ~serr_req;
      cfg_commit <= commit_d;
    end
  end
endmodule

// File: rtl/bpr_sts_bits.sv
module bpr_sts_bits #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         sts[i] <= 1'b0;
      else if (set[i]) sts[i] <= 1'b1;
      else if (clr[i]) sts[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/bpr_unit.sv
module bpr_unit
  import bpr_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int BE_W = AD_W / 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AD_W-1:0] pri_ad,
  input  logic [BE_W-1:0] pri_cbe,
  input  logic            pri_par,
  input  logic            pri_addr_ph,
  input  logic            pri_data_ph,
  input  logic            pri_cfg0_wr,
  input  logic [AD_W-1:0] sec_ad,
  input  logic [BE_W-1:0] sec_cbe,
  input  logic            sec_par,
  input  logic            sec_addr_ph,
  input  logic            sec_hit,
  input  logic            cmd_perr_en,
  input  logic            cmd_serr_en,
  input  logic            bctl_perr_en,
  input  logic [NSTS-1:0] sts_clr,
  output logic [NSTS-1:0] err_sts,
  output logic            sec_claim,
  output logic            perr_n,
  output logic            serr_n,
  output logic            cfg_commit
);
  par_chk_t        pri_res, sec_res;
  logic [NSTS-1:0] sts_set;
  logic            sec_aerr;

  bpr_par_chk #(.AD_W(AD_W), .BE_W(BE_W)) u_pri_chk (
    .clk(clk), .rst(rst), .ad(pri_ad), .cbe(pri_cbe), .par(pri_par),
    .addr_ph(pri_addr_ph), .data_ph(pri_data_ph), .tag(pri_cfg0_wr),
    .res(pri_res)
  );

  bpr_par_chk #(.AD_W(AD_W), .BE_W(BE_W)) u_sec_chk (
    .clk(clk), .rst(rst), .ad(sec_ad), .cbe(sec_cbe), .par(sec_par),
    .addr_ph(sec_addr_ph), .data_ph(1'b0), .tag(sec_hit),
    .res(sec_res)
  );

  assign sec_aerr = sec_res.addr_err;

  bpr_err_policy u_policy (
    .clk(clk), .rst(rst), .pri(pri_res), .sec(sec_res),
    .cmd_perr_en(cmd_perr_en), .cmd_serr_en(cmd_serr_en),
    .bctl_perr_en(bctl_perr_en), .sts_set(sts_set),
    .sec_claim(sec_claim), .perr_n(perr_n), .serr_n(serr_n),
    .cfg_commit(cfg_commit)
  );

  bpr_sts_bits #(.N(NSTS)) u_sts (
    .clk(clk), .rst(rst), .set(sts_set), .clr(sts_clr), .sts(err_sts)
  );
endmodule

// File: rtl/bpr_unit_chk.sv
module bpr_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       cmd_perr_en,
  input logic       cmd_serr_en,
  input logic       bctl_perr_en,
  input logic [2:0] sts_clr,
  input logic [2:0] err_sts,
  input logic       sec_claim,
  input logic       perr_n,
  input logic       serr_n,
  input logic       sec_aerr
);
  p_perr_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    !perr_n |=> perr_n);

  p_serr_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    !serr_n |=> serr_n);

  p_serr_sets_sse_r4: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> err_sts[1]);

  p_serr_needs_en_r4: assert property (@(posedge clk) disable iff (rst)
    !serr_n |-> $past(cmd_serr_en));

  p_perr_needs_en_r6: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> $past(cmd_perr_en));

  p_perr_sets_dpe_r7: assert property (@(posedge clk) disable iff (rst)
    !perr_n |-> err_sts[0]);

  p_claim_withheld_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(sec_aerr) && $past(bctl_perr_en)) |-> !sec_claim);

  for (genvar i = 0; i < 3; i++) begin : g_sticky
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      (err_sts[i] && !sts_clr[i]) |=> err_sts[i]);
  end
endmodule

bind bpr_unit bpr_unit_chk u_chk (
  .clk(clk), .rst(rst), .cmd_perr_en(cmd_perr_en),
  .cmd_serr_en(cmd_serr_en), .bctl_perr_en(bctl_perr_en),
  .sts_clr(sts_clr), .err_sts(err_sts), .sec_claim(sec_claim),
  .perr_n(perr_n), .serr_n(serr_n), .sec_aerr(sec_aerr)
);

// File: tb/bpr_unit_bench.sv
`timescale 1ns/1ps
module bpr_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] pri_ad = '0, sec_ad = '0;
  logic [3:0]  pri_cbe = '0, sec_cbe = '0;
  logic pri_par = 0, sec_par = 0, pri_addr_ph = 0, pri_data_ph = 0;
  logic pri_cfg0_wr = 0, sec_addr_ph = 0, sec_hit = 0;
  logic cmd_perr_en = 0, cmd_serr_en = 0, bctl_perr_en = 0;
  logic [2:0] sts_clr = '0;
  logic [2:0] err_sts;
  logic sec_claim, perr_n, serr_n, cfg_commit;

  int checks = 0, fails = 0, seq = 0;
  logic [2:0] s_sts;
  logic s_claim, s_perr, s_serr, s_commit, n_perr, n_serr, n_claim, n_commit;

  always #2.5 clk = ~clk;

  bpr_unit u_bpr_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One phase on the selected bus(es); flip: 0 none, 1 AD bit, 2 PAR
  task automatic run(input bit pa, input bit pd, input bit pcfg, input bit sa,
                     input bit shit, input int pflip, input int sflip,
                     input logic [2:0] clr_t1);
    logic [31:0] pv, sv;
    logic pp, sp;
    seq++;
    pv = 32'h9E37_79B9 * seq;
    sv = 32'h6A09_E667 ^ (seq * 32'h0101_0407);
    @(negedge clk);
    pri_ad = (pflip == 1) ? pv ^ (32'h1 << (seq % 32)) : pv;
    pri_cbe = pv[3:0]; pp = ^{pv, pv[3:0]};
    sec_ad = (sflip == 1) ? sv ^ (32'h1 << ((seq * 7) % 32)) : sv;
    sec_cbe = sv[7:4]; sp = ^{sv, sv[7:4]};
    pri_addr_ph = pa; pri_data_ph = pd; pri_cfg0_wr = pcfg;
    sec_addr_ph = sa; sec_hit = shit;
    @(negedge clk);
    pri_addr_ph = 0; pri_data_ph = 0; pri_cfg0_wr = 0; sec_addr_ph = 0; sec_hit = 0;
    pri_par = pp ^ (pflip == 2); sec_par = sp ^ (sflip == 2);
    sts_clr = clr_t1;
    @(negedge clk);
    sts_clr = '0; pri_par = 0; sec_par = 0;
    s_sts = err_sts; s_claim = sec_claim; s_perr = perr_n; s_serr = serr_n;
    s_commit = cfg_commit;
    @(negedge clk);
    n_perr = perr_n; n_serr = serr_n; n_claim = sec_claim; n_commit = cfg_commit;
  endtask

  task automatic clear_all();
    @(negedge clk); sts_clr = 3'b111;
    @(negedge clk); sts_clr = '0;
  endtask

  task automatic t_reset();
    chk("R11 sts", err_sts, 3'b000);
    chk("R11 perr_n", perr_n, 1'b1);
    chk("R11 serr_n", serr_n, 1'b1);
    chk("R11 claim", sec_claim, 1'b0);
    chk("R11 commit", cfg_commit, 1'b0);
  endtask

  task automatic t_sec_addr();
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 3; f++) begin
        bit err;
        err = (f != 0);
        {cmd_perr_en, cmd_serr_en, bctl_perr_en} = e[2:0];
        clear_all();
        run(0, 0, 0, 1, 1, 0, f, 3'b000);
        chk("R2 claim", s_claim, !(err && bctl_perr_en));
        chk("R1 R2 claim one clock", n_claim, 1'b0);
        chk("R3 sec detected", s_sts[2], err);
        chk("R4 serr_n", s_serr, !(err && cmd_serr_en && bctl_perr_en));
        chk("R4 sse", s_sts[1], err && cmd_serr_en && bctl_perr_en);
        chk("R9 serr one clock", n_serr, 1'b1);
        chk("R1 no primary effect", {s_sts[0], s_perr}, 2'b01);
      end
    end
    clear_all();
    run(0, 0, 0, 1, 0, 0, 0, 3'b000);
    chk("R2 no hit no claim", s_claim, 1'b0);
  endtask

  task automatic t_pri_addr();
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 3; f++) begin
        bit err;
        err = (f != 0);
        {cmd_perr_en, cmd_serr_en, bctl_perr_en} = e[2:0];
        clear_all();
        run(1, 0, 0, 0, 0, f, 0, 3'b000);
        chk("R5 pri detected", s_sts[0], err);
        chk("R5 serr_n", s_serr, !(err && cmd_serr_en && cmd_perr_en));
        chk("R5 sse", s_sts[1], err && cmd_serr_en && cmd_perr_en);
        chk("R5 no perr", s_perr, 1'b1);
        chk("R1 no secondary effect", {s_sts[2], s_claim}, 2'b00);
      end
    end
  endtask

  task automatic t_cfg_wr();
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 3; f++) begin
        bit err;
        err = (f != 0);
        {cmd_perr_en, cmd_serr_en, bctl_perr_en} = e[2:0];
        clear_all();
        run(0, 1, 1, 0, 0, f, 0, 3'b000);
        chk("R6 commit", s_commit, 1'b1);
        chk("R6 commit one clock", n_commit, 1'b0);
        chk("R6 perr_n", s_perr, !(err && cmd_perr_en));
        chk("R9 perr one clock", n_perr, 1'b1);
        chk("R7 pri detected", s_sts[0], err);
        chk("R6 no serr", {s_serr, s_sts[1]}, 2'b10);
      end
    end
  endtask

  task automatic t_unchecked();
    {cmd_perr_en, cmd_serr_en, bctl_perr_en} = 3'b111;
    clear_all();
    run(0, 1, 0, 0, 0, 2, 0, 3'b000);
    chk("R10 perr_n", s_perr, 1'b1);
    chk("R10 serr_n", s_serr, 1'b1);
    chk("R10 commit", s_commit, 1'b0);
    chk("R10 sts", s_sts, 3'b000);
  endtask

  task automatic t_w1c();
    {cmd_perr_en, cmd_serr_en, bctl_perr_en} = 3'b111;
    clear_all();
    run(1, 0, 0, 1, 1, 2, 2, 3'b000);
    chk("R9 coincident serr", {s_serr, n_serr}, 2'b01);
    chk("R8 all set", s_sts, 3'b111);
    @(negedge clk); sts_clr = 3'b001;
    @(negedge clk); sts_clr = 3'b000;
    chk("R8 clear bit0 only", err_sts, 3'b110);
    @(negedge clk); sts_clr = 3'b100;
    @(negedge clk); sts_clr = 3'b000;
    chk("R8 clear bit2 only", err_sts, 3'b010);
    @(negedge clk);
    chk("R8 sticky", err_sts, 3'b010);
    clear_all();
    chk("R8 all cleared", err_sts, 3'b000);
    run(0, 1, 1, 0, 0, 1, 0, 3'b001);
    chk("R8 set wins over clear", s_sts[0], 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sec_addr();
    t_pri_addr();
    t_cfg_wr();
    t_unchecked();
    t_w1c();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule